// File: doc/BRIEF.md
# Oversampling Asynchronous Receiver with Per-Character Error Status

This block takes a serial receive line and turns it back into characters. It does not run on a divided clock. It runs on the system clock and steps only on a sample-enable pulse, which arrives 16 times per bit period, or 8 times in double-speed mode. While the line is idle it rests high. A high-to-low transition opens a candidate start bit. Each bit's value is settled by a two-of-three vote taken on the middle samples of that bit. The vote rejects short glitches, and it also drops start bits that prove to be noise.

Each character can carry 5 to 9 data bits, sent LSB first, then an optional parity bit and then the stop bit. The block checks parity and the first stop bit. It puts the character into a two-entry receive queue, and the frame error and parity error flags travel in the same entry. A character that arrives while the queue is full is discarded. The loss is marked on the newest character already held in the queue. A consumer watches `rxReady`, takes the head character and its flags, and pulses `readStrobe` to advance to the next entry.

Top module: `async_rx_core`

## Requirements
- R1: After reset the queue is empty. `rxReady`, `rdData`, `rdBit8`, `frameErr`, `parityErr` and `overrun` are all 0.
- R2: `charBits` selects 5 to 9 data bits. Values below 5 act as 5 and values above 9 act as 9. The first received bit lands in `rdData[0]` and the character is right-aligned. Data bits above the configured count read 0. With 9 bits the last data bit appears on `rdBit8`. With fewer bits `rdBit8` is 0.
- R3: When `doubleSpeed` is 0 a bit spans 16 sample pulses, and when it is 1 a bit spans 8. The value of a bit is the majority of samples 7, 8 and 9 (or 3, 4 and 5 at double speed), counted from the first sample that sees the start edge. An inversion of the line that lasts a single sample pulse does not change the character.
- R4: A falling edge whose mid-bit vote comes out high is treated as a false start. It produces no character, and the receiver then accepts the next real frame normally.
- R5: `parityMode` 2'b10 selects even parity and 2'b11 selects odd parity. With 2'b00 or 2'b01 no parity bit is expected. `parityErr` is 1 when parity is enabled and the data bits plus the received parity bit do not give the selected sum. The character is stored either way.
- R6: `frameErr` is 1 when the vote for the first stop bit is low. Further stop bits are never checked. A start edge that follows the first stop bit directly is accepted, so frames sent back to back with one stop bit are all received.
- R7: The queue holds two characters in arrival order. `rxReady` is 1 while at least one character is held. `readStrobe` removes the head. A `readStrobe` while the queue is empty has no effect.
- R8: A character that completes while the queue holds two characters is discarded and the queue contents are unchanged, except that the `overrun` flag of the newest held character is set to 1.
- R9: `frameErr`, `parityErr` and `overrun` belong to the character currently at the head of the queue. They change when the head changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleTick | input | 1 | Oversampling enable, one pulse per sample period |
| rxLine | input | 1 | Serial receive line, idle high |
| doubleSpeed | input | 1 | 1: 8 samples per bit, 0: 16 samples per bit |
| charBits | input | 4 | Data bits per character (5 to 9) |
| parityMode | input | 2 | 0x: none, 10: even, 11: odd |
| readStrobe | input | 1 | Removes the head character |
| rxReady | output | 1 | Queue holds at least one character |
| rdData | output | 8 | Data bits 0 to 7 of the head character |
| rdBit8 | output | 1 | Data bit 8 of the head character |
| frameErr | output | 1 | Head character had a low first stop bit |
| parityErr | output | 1 | Head character failed the parity check |
| overrun | output | 1 | Characters were lost after the head character |

## Verification
The bench uses the default parameters: 16 and 8 samples per bit, a two-stage input synchronizer and a two-entry queue. It pulses `sampleTick` on every second clock, so the synchronizer delay and the tick phase shift the vote window by a fraction of a sample. This lets a one-sample glitch placed at mid-bit land on exactly one of the three voted samples. The depth of two makes the queue fill after two characters, so the third character reaches the overrun path. Both oversampling ratios are used, together with the 5-, 7-, 8- and 9-bit formats.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

  localparam int MIN_DATA_BITS = 5;
  localparam int MAX_DATA_BITS = 9;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PARITY,
    RX_STOP
  } rxState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic capLo;      // store the first of the three voted samples
    logic capMid;     // store the second voted sample
    logic decide;     // third sample present: vote is valid now
    logic shiftIn;    // vote is a data bit
    logic takeParity; // vote is the parity bit
    logic clearFrame; // new start edge: clear assembly state
    logic pushFrame;  // vote is the first stop bit: emit character
  } rxStrobe_t;

  typedef struct packed {
    logic [MAX_DATA_BITS-1:0] data;
    logic                     frameErr;
    logic                     parityErr;
  } rxChar_t;

  function automatic logic [3:0] clampBits(input logic [3:0] req);
    if (req < 4'(MIN_DATA_BITS)) return 4'(MIN_DATA_BITS);
    if (req > 4'(MAX_DATA_BITS)) return 4'(MAX_DATA_BITS);
    return req;
  endfunction

endpackage

// File: rtl/async_rx_ctrl.sv
module async_rx_ctrl
  import async_rx_pkg::*;
#(
  parameter int OSR_NORMAL = 16,
  parameter int OSR_DOUBLE = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleTick,
  input  logic       lineNow,
  input  logic       voteBit,
  input  logic       doubleSpeed,
  input  logic       parityOn,
  input  logic [3:0] effBits,
  output rxStrobe_t  strobe
);

  localparam int CW = $clog2(OSR_NORMAL + 1);

  rxState_t      state;
  logic [CW-1:0] smpIdx;
  logic [3:0]    bitIdx;
  logic          prevLine;

  logic [CW-1:0] osr;
  logic [CW-1:0] midIdx;
  logic [CW-1:0] lastIdx;
  logic          inFrame;
  logic          startEdge;
  logic          endOfBit;

  assign osr       = doubleSpeed ? CW'(OSR_DOUBLE) : CW'(OSR_NORMAL);
  assign midIdx    = osr >> 1;
  assign lastIdx   = osr - CW'(1);
  assign inFrame   = sampleTick && (state != RX_IDLE);
  assign startEdge = sampleTick && (state == RX_IDLE) && prevLine && !lineNow;
  assign endOfBit  = inFrame && (smpIdx == lastIdx);

  always_comb begin
    strobe            = '0;
    strobe.capLo      = inFrame && (smpIdx == midIdx - CW'(1));
    strobe.capMid     = inFrame && (smpIdx == midIdx);
    strobe.decide     = inFrame && (smpIdx == midIdx + CW'(1));
    strobe.shiftIn    = strobe.decide && (state == RX_DATA);
    strobe.takeParity = strobe.decide && (state == RX_PARITY);
    strobe.pushFrame  = strobe.decide && (state == RX_STOP);
    strobe.clearFrame = startEdge;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= RX_IDLE;
      smpIdx   <= '0;
      bitIdx   <= '0;
      prevLine <= 1'b1;
    end else begin
      if (sampleTick) prevLine <= lineNow;
      if (startEdge) begin
        state  <= RX_START;
        smpIdx <= CW'(1);
        bitIdx <= '0;
      end else if (inFrame) begin
        smpIdx <= endOfBit ? '0 : smpIdx + CW'(1);
        unique case (state)
          RX_START: begin
            if (strobe.decide && voteBit) state <= RX_IDLE;
            else if (endOfBit)            state <= RX_DATA;
          end
          RX_DATA: begin
            if (endOfBit) begin
              bitIdx <= bitIdx + 4'd1;
              if (bitIdx == effBits - 4'd1)
                state <= parityOn ? RX_PARITY : RX_STOP;
            end
          end
          RX_PARITY: if (endOfBit) state <= RX_STOP;
          RX_STOP:   if (strobe.decide) state <= RX_IDLE;
          default:   state <= RX_IDLE;
        endcase
      end
    end
  end

  // R4: a high mid-bit vote during the start bit abandons the frame
  a_r4_false_start_abort : assert property (@(posedge clk) disable iff (!rstN)
    (state == RX_START && strobe.decide && voteBit) |=> (state == RX_IDLE));

  // R6: the first stop bit vote closes the frame, ready for the next edge
  a_r6_stop_ends_frame : assert property (@(posedge clk) disable iff (!rstN)
    strobe.pushFrame |=> (state == RX_IDLE));

  // R3: sample index stays inside one bit period while framing
  a_r3_index_in_bit : assert property (@(posedge clk) disable iff (!rstN)
    (state != RX_IDLE) |-> (smpIdx <= lastIdx));

endmodule

// File: rtl/async_rx_datapath.sv
module async_rx_datapath
  import async_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxLine,
  input  rxStrobe_t  strobe,
  input  logic [3:0] effBits,
  input  logic       parityOn,
  input  logic       oddParity,
  output logic       lineNow,
  output logic       voteBit,
  output logic       pushValid,
  output rxChar_t    pushChar
);

  logic [SYNC_STAGES-1:0]   syncReg;
  logic                     smpLo;
  logic                     smpMid;
  logic [MAX_DATA_BITS-1:0] shiftReg;
  logic                     parityAcc;
  logic                     parityBit;
  logic [3:0]               shiftAmt;

  assign lineNow   = syncReg[SYNC_STAGES-1];
  assign voteBit   = (smpLo & smpMid) | (smpLo & lineNow) | (smpMid & lineNow);
  assign shiftAmt  = 4'(MAX_DATA_BITS) - effBits;
  assign pushValid = strobe.pushFrame;

  always_comb begin
    pushChar.data      = shiftReg >> shiftAmt;
    pushChar.frameErr  = !voteBit;
    pushChar.parityErr = parityOn && (parityAcc ^ parityBit ^ oddParity);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncReg   <= '1;
      smpLo     <= 1'b1;
      smpMid    <= 1'b1;
      shiftReg  <= '0;
      parityAcc <= 1'b0;
      parityBit <= 1'b0;
    end else begin
      syncReg <= {syncReg[SYNC_STAGES-2:0], rxLine};
      if (strobe.capLo)  smpLo  <= lineNow;
      if (strobe.capMid) smpMid <= lineNow;
      if (strobe.clearFrame) begin
        shiftReg  <= '0;
        parityAcc <= 1'b0;
      end else if (strobe.shiftIn) begin
        shiftReg  <= {voteBit, shiftReg[MAX_DATA_BITS-1:1]};
        parityAcc <= parityAcc ^ voteBit;
      end
      if (strobe.takeParity) parityBit <= voteBit;
    end
  end

  // R2: characters narrower than nine bits never carry a ninth bit
  a_r2_narrow_no_bit8 : assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && effBits != 4'(MAX_DATA_BITS)) |-> (pushChar.data[MAX_DATA_BITS-1] == 1'b0));

endmodule

// File: rtl/async_rx_fifo.sv
module async_rx_fifo
  import async_rx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    push,
  input  rxChar_t pushChar,
  input  logic    pop,
  output rxChar_t headChar,
  output logic    headOverrun,
  output logic    notEmpty
);

  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);

  rxChar_t         mem [DEPTH];
  logic [DEPTH-1:0] ovrMem;
  logic [PW-1:0]   wrPtr;
  logic [PW-1:0]   rdPtr;
  logic [PW-1:0]   lastWr;
  logic [CNTW-1:0] count;
  logic            full;
  logic            doPop;
  logic            accept;
  logic            overrunEv;

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full      = (count == FULL_CNT);
  assign doPop     = pop && (count != '0);
  assign accept    = push && (!full || doPop);
  assign overrunEv = push && full && !doPop;
  assign lastWr    = (wrPtr == '0) ? PW'(DEPTH - 1) : wrPtr - PW'(1);

  assign headChar    = mem[rdPtr];
  assign headOverrun = ovrMem[rdPtr];
  assign notEmpty    = (count != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      ovrMem <= '0;
      wrPtr  <= '0;
      rdPtr  <= '0;
      count  <= '0;
    end else begin
      if (accept) begin
        mem[wrPtr]    <= pushChar;
        ovrMem[wrPtr] <= 1'b0;
        wrPtr         <= nextPtr(wrPtr);
      end
      if (overrunEv) ovrMem[lastWr] <= 1'b1;
      if (doPop) rdPtr <= nextPtr(rdPtr);
      count <= count + CNTW'(accept) - CNTW'(doPop);
    end
  end

  // R7: occupancy never exceeds the queue depth
  a_r7_count_bound : assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);

  // R7: a read of a non-empty queue without a push removes one entry
  a_r7_pop_drains : assert property (@(posedge clk) disable iff (!rstN)
    (pop && count != '0 && !push) |=> (count == $past(count) - CNTW'(1)));

  // R8: a push into a full queue leaves it full
  a_r8_full_stays_full : assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !pop) |=> full);

  // R8: the lost character marks the newest stored entry
  a_r8_flag_marked : assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !pop) |=> ovrMem[$past(lastWr)]);

endmodule

// File: rtl/async_rx_core.sv
module async_rx_core
  import async_rx_pkg::*;
#(
  parameter int OSR_NORMAL  = 16,
  parameter int OSR_DOUBLE  = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FIFO_DEPTH  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleTick,
  input  logic       rxLine,
  input  logic       doubleSpeed,
  input  logic [3:0] charBits,
  input  logic [1:0] parityMode,
  input  logic       readStrobe,
  output logic       rxReady,
  output logic [7:0] rdData,
  output logic       rdBit8,
  output logic       frameErr,
  output logic       parityErr,
  output logic       overrun
);

  rxStrobe_t  strobe;
  rxChar_t    pushChar;
  rxChar_t    headChar;
  logic       lineNow;
  logic       voteBit;
  logic       pushValid;
  logic [3:0] effBits;

  assign effBits = clampBits(charBits);

  async_rx_ctrl #(
    .OSR_NORMAL(OSR_NORMAL),
    .OSR_DOUBLE(OSR_DOUBLE)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .sampleTick (sampleTick),
    .lineNow    (lineNow),
    .voteBit    (voteBit),
    .doubleSpeed(doubleSpeed),
    .parityOn   (parityMode[1]),
    .effBits    (effBits),
    .strobe     (strobe)
  );

  async_rx_datapath #(
    .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .rxLine   (rxLine),
    .strobe   (strobe),
    .effBits  (effBits),
    .parityOn (parityMode[1]),
    .oddParity(parityMode[0]),
    .lineNow  (lineNow),
    .voteBit  (voteBit),
    .pushValid(pushValid),
    .pushChar (pushChar)
  );

  async_rx_fifo #(
    .DEPTH(FIFO_DEPTH)
  ) fifo_i (
    .clk        (clk),
    .rstN       (rstN),
    .push       (pushValid),
    .pushChar   (pushChar),
    .pop        (readStrobe),
    .headChar   (headChar),
    .headOverrun(overrun),
    .notEmpty   (rxReady)
  );

  assign rdData    = headChar.data[7:0];
  assign rdBit8    = headChar.data[8];
  assign frameErr  = headChar.frameErr;
  assign parityErr = headChar.parityErr;

endmodule

// File: tb/async_rx_core_tb_top.sv
module async_rx_core_tb_top;

  localparam int TDIV = 2;
  localparam int OSRN = 16;
  localparam int OSRD = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleTick = 1'b0;
  logic       rxLine = 1'b1;
  logic       doubleSpeed = 1'b0;
  logic [3:0] charBits = 4'd8;
  logic [1:0] parityMode = 2'b00;
  logic       readStrobe = 1'b0;
  logic       rxReady;
  logic [7:0] rdData;
  logic       rdBit8;
  logic       frameErr;
  logic       parityErr;
  logic       overrun;

  int checks = 0;
  int failures = 0;
  int tickPh = 0;

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    tickPh     <= (tickPh == TDIV - 1) ? 0 : tickPh + 1;
    sampleTick <= (tickPh == TDIV - 1);
  end

  async_rx_core dut_i (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .doubleSpeed(doubleSpeed), .charBits(charBits), .parityMode(parityMode),
    .readStrobe(readStrobe), .rxReady(rxReady), .rdData(rdData), .rdBit8(rdBit8),
    .frameErr(frameErr), .parityErr(parityErr), .overrun(overrun)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic driveBit(input logic b, input int osr, input bit glitch);
    for (int c = 0; c < osr * TDIV; c++) begin
      rxLine = (glitch && c >= (osr / 2) * TDIV && c < (osr / 2 + 1) * TDIV) ? ~b : b;
      @(negedge clk);
    end
  endtask

  // parMode: 0 none, 1 even, 2 odd
  task automatic sendFrame(input logic [8:0] val, input int nBits, input int parMode,
                           input bit flipPar, input logic stopVal, input int idleBits,
                           input int glitchAt);
    int osr;
    logic p;
    osr = doubleSpeed ? OSRD : OSRN;
    p = 1'b0;
    driveBit(1'b0, osr, 1'b0);
    for (int i = 0; i < nBits; i++) begin
      driveBit(val[i], osr, glitchAt == i);
      p ^= val[i];
    end
    if (parMode != 0) driveBit(p ^ (parMode == 2) ^ flipPar, osr, 1'b0);
    driveBit(stopVal, osr, 1'b0);
    for (int i = 0; i < idleBits; i++) driveBit(1'b1, osr, 1'b0);
  endtask

  task automatic popHead();
    readStrobe = 1'b1;
    @(negedge clk);
    readStrobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic checkHead(input string req, input int data, input int b8,
                           input int fe, input int pe, input int ovr);
    chk(req, "rxReady", rxReady, 1);
    chk(req, "rdData", rdData, data);
    chk(req, "rdBit8", rdBit8, b8);
    chk(req, "frameErr", frameErr, fe);
    chk(req, "parityErr", parityErr, pe);
    chk(req, "overrun", overrun, ovr);
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "rxReady", rxReady, 0);
    chk("R1", "rdData", rdData, 0);
    chk("R1", "rdBit8", rdBit8, 0);
    chk("R1", "frameErr", frameErr, 0);
    chk("R1", "parityErr", parityErr, 0);
    chk("R1", "overrun", overrun, 0);
  endtask

  task automatic t_basic();
    doubleSpeed = 0; charBits = 4'd8; parityMode = 2'b00;
    sendFrame(9'h0A5, 8, 0, 0, 1'b1, 2, -1);
    checkHead("R2", 8'hA5, 0, 0, 0, 0);
    popHead();
    chk("R7", "rxReady after pop", rxReady, 0);
  endtask

  task automatic t_double();
    doubleSpeed = 1; charBits = 4'd8; parityMode = 2'b00;
    sendFrame(9'h03C, 8, 0, 0, 1'b1, 2, -1);
    checkHead("R3", 8'h3C, 0, 0, 0, 0);
    popHead();
    doubleSpeed = 0;
  endtask

  task automatic t_widths();
    parityMode = 2'b00;
    charBits = 4'd5;
    sendFrame(9'h015, 5, 0, 0, 1'b1, 2, -1);
    checkHead("R2", 8'h15, 0, 0, 0, 0);
    popHead();
    charBits = 4'd7;
    sendFrame(9'h05B, 7, 0, 0, 1'b1, 2, -1);
    checkHead("R2", 8'h5B, 0, 0, 0, 0);
    popHead();
    charBits = 4'd9;
    sendFrame(9'h1A5, 9, 0, 0, 1'b1, 2, -1);
    checkHead("R2", 8'hA5, 1, 0, 0, 0);
    popHead();
    charBits = 4'd3;  // clamps to 5
    sendFrame(9'h00A, 5, 0, 0, 1'b1, 2, -1);
    checkHead("R2", 8'h0A, 0, 0, 0, 0);
    popHead();
    charBits = 4'd8;
  endtask

  task automatic t_parity();
    charBits = 4'd8;
    parityMode = 2'b10;
    sendFrame(9'h0B7, 8, 1, 0, 1'b1, 2, -1);
    checkHead("R5", 8'hB7, 0, 0, 0, 0);
    popHead();
    sendFrame(9'h0B7, 8, 1, 1, 1'b1, 2, -1);
    checkHead("R5", 8'hB7, 0, 0, 1, 0);
    popHead();
    parityMode = 2'b11;
    sendFrame(9'h021, 8, 2, 0, 1'b1, 2, -1);
    checkHead("R5", 8'h21, 0, 0, 0, 0);
    popHead();
    sendFrame(9'h021, 8, 2, 1, 1'b1, 2, -1);
    checkHead("R5", 8'h21, 0, 0, 1, 0);
    popHead();
    parityMode = 2'b00;
  endtask

  task automatic t_frame();
    sendFrame(9'h081, 8, 0, 0, 1'b0, 2, -1);
    sendFrame(9'h042, 8, 0, 0, 1'b1, 2, -1);
    checkHead("R6", 8'h81, 0, 1, 0, 0);
    popHead();
    checkHead("R9", 8'h42, 0, 0, 0, 0);
    popHead();
  endtask

  task automatic t_backToBack();
    sendFrame(9'h0C3, 8, 0, 0, 1'b1, 0, -1);
    sendFrame(9'h03E, 8, 0, 0, 1'b1, 2, -1);
    checkHead("R6", 8'hC3, 0, 0, 0, 0);
    popHead();
    checkHead("R6", 8'h3E, 0, 0, 0, 0);
    popHead();
  endtask

  task automatic t_fifo();
    popHead();  // read while empty
    chk("R7", "rxReady after empty read", rxReady, 0);
    sendFrame(9'h011, 8, 0, 0, 1'b1, 2, -1);
    sendFrame(9'h022, 8, 0, 0, 1'b1, 2, -1);
    checkHead("R7", 8'h11, 0, 0, 0, 0);
    popHead();
    checkHead("R7", 8'h22, 0, 0, 0, 0);
    popHead();
    chk("R7", "rxReady drained", rxReady, 0);
  endtask

  task automatic t_overrun();
    sendFrame(9'h0A1, 8, 0, 0, 1'b1, 1, -1);
    sendFrame(9'h0B2, 8, 0, 0, 1'b1, 1, -1);
    sendFrame(9'h0C3, 8, 0, 0, 1'b1, 2, -1);
    checkHead("R8", 8'hA1, 0, 0, 0, 0);
    popHead();
    checkHead("R8", 8'hB2, 0, 0, 0, 1);
    popHead();
    chk("R8", "third char discarded", rxReady, 0);
  endtask

  task automatic t_falseStart();
    rxLine = 1'b0;
    repeat (3 * TDIV) @(negedge clk);
    rxLine = 1'b1;
    repeat (2 * OSRN * TDIV) @(negedge clk);
    chk("R4", "no char after false start", rxReady, 0);
    sendFrame(9'h077, 8, 0, 0, 1'b1, 2, -1);
    checkHead("R4", 8'h77, 0, 0, 0, 0);
    popHead();
  endtask

  task automatic t_glitch();
    sendFrame(9'h0F0, 8, 0, 0, 1'b1, 2, 1);
    checkHead("R3", 8'hF0, 0, 0, 0, 0);
    popHead();
    doubleSpeed = 1;
    sendFrame(9'h0F0, 8, 0, 0, 1'b1, 2, 6);
    checkHead("R3", 8'hF0, 0, 0, 0, 0);
    popHead();
    doubleSpeed = 0;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    repeat (4 * OSRN * TDIV) @(negedge clk);
    t_basic();
    t_double();
    t_widths();
    t_parity();
    t_frame();
    t_backToBack();
    t_fifo();
    t_overrun();
    t_falseStart();
    t_glitch();
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired (R1..) actual=hung expected=done");
    summary();
    $finish;
  end

endmodule